// File: doc/BRIEF.md
# Memory Read-Modify-Write Incrementer

This unit adds or subtracts one from a value that lives in memory, either a single byte or a 16-bit word stored low byte first. The memory is byte-wide and split into three spaces (a normal space and two auxiliary spaces, X and Y). A controller supplies a one-cycle start pulse together with the base address, the operation (count up or down, byte or word, and whether the byte form depends on the X flag), a selector that names the space, and the current flag byte. The unit then runs a short read-then-write sequence on a synchronous memory port and returns a one-cycle done pulse with the updated flag byte.

The selector is given either as a register code or as an index code, and is decoded once when the operation is accepted. The conditional byte forms run only when the incoming X flag is set. When X is clear they complete at once, with no memory access and with the flags unchanged. Read data on the memory port is expected one cycle after the address is presented.

Flag byte layout used throughout: bit 7 S (sign), bit 6 Z (zero), bit 5 unused and passed through, bit 4 H (half), bit 3 X (extended carry), bit 2 V (overflow), bit 1 N (subtract), bit 0 C (carry).

Top module: `rmw_incdec`

## Requirements
- R1: A word operation reads base, then base+1, then writes the new low byte to base and the new high byte to base+1. Each read returns data one cycle after its address. The value is treated as {byte at base+1, byte at base}.
- R2: With sel_index low, mem_space is 1 (X) when sel_code[2:0]==4, 2 (Y) when it is 5, and 0 (normal) otherwise. With sel_index high, mem_space is 1 when sel_code[1:0]==0, 2 when it is 1, and 0 otherwise. The space stays fixed for the whole operation.
- R3: Byte increment sets S to bit 7 of the result, Z to result==0, and H to result[3:0]==0. X is set when the operand was 0xFF and cleared otherwise. V is set when the operand was 0x7F and left unchanged otherwise. N, C and bit 5 are unchanged.
- R4: Byte decrement sets S, Z and H in the same way as R3, and sets N. X is set when the operand was 0x00 and cleared otherwise. V is set when the operand was 0x80 and left unchanged otherwise. C and bit 5 are unchanged.
- R5: Word increment sets S to bit 15 of the result, Z to result==0, and X to result==0, and clears N. V is set when the operand was 0xFFFF and left unchanged otherwise. H, C and bit 5 are unchanged.
- R6: Word decrement sets S and Z as in R5, sets X when the result is 0xFFFF and clears it otherwise, and clears N. V is set when the operand was 0x0000 and left unchanged otherwise. H, C and bit 5 are unchanged.
- R7: A byte operation with only_if_x high and flags_in bit 3 clear raises done in the first cycle after start, performs no write, and returns flags_out equal to flags_in. With bit 3 set it behaves as the plain byte form. only_if_x has no effect on word forms.
- R8: done is high for exactly one cycle. It comes in the 3rd cycle after the start cycle for byte forms and in the 5th for word forms. flags_out changes only in the cycle where done is high and holds its value until the next done.
- R9: A start that arrives while an operation is in progress, including the cycle where done is high, is ignored. It causes no access and no extra done.
- R10: The written bytes equal the incremented or decremented value, wrapping modulo 256 or 65536. A byte form writes exactly one byte and leaves base+1 untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| dec_mode | input | 1 | 1 = decrement, 0 = increment |
| word_mode | input | 1 | 1 = 16-bit word, 0 = byte |
| only_if_x | input | 1 | Byte form runs only when flag X is set |
| sel_index | input | 1 | 1 = sel_code is an index code, 0 = register code |
| sel_code | input | 8 | Space selector code |
| base_addr | input | ADDR_W | Address of the byte or the low byte |
| flags_in | input | 8 | Flag byte before the operation |
| flags_out | output | 8 | Flag byte after the last operation |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Memory address |
| mem_space | output | 2 | 0 normal, 1 X, 2 Y |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |

## Verification
The two events that can land in one cycle are a fresh start request and the completion pulse of the operation still running. The bench drives that overlap by keeping start high, with a different target address, from the first busy cycle through the done cycle. The run passes only if the original result is written, the decoy address keeps its contents in every space, and no second done follows. The rest of the bench sweeps every byte operand in both directions, a set of word operands around the carry and sign edges, every selector code, and both outcomes of the conditional form.

// File: rtl/rmw_pkg.sv
// Package: shared types and constants for the read-modify-write incrementer.
// Assumes an 8-bit flag byte with the bit layout listed below.
package rmw_pkg;

    // Flag bit positions inside the flag byte
    localparam int FLAG_S = 7;
    localparam int FLAG_Z = 6;
    localparam int FLAG_H = 4;
    localparam int FLAG_X = 3;
    localparam int FLAG_V = 2;
    localparam int FLAG_N = 1;
    localparam int FLAG_C = 0;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_READ_LO  = 3'd1,
        ST_READ_HI  = 3'd2,
        ST_WRITE_LO = 3'd3,
        ST_WRITE_HI = 3'd4,
        ST_DONE     = 3'd5
    } rmw_state_t;

    // Memory space encoding on the port
    typedef enum logic [1:0] {
        SPACE_NORMAL = 2'd0,
        SPACE_X      = 2'd1,
        SPACE_Y      = 2'd2
    } space_t;

    // Operation descriptor latched at start
    typedef struct packed {
        logic dec;
        logic word;
        logic only_if_x;
    } rmw_op_t;

endpackage

// File: rtl/rmw_space_decode.sv
// Module: rmw_space_decode
// Turns a selector code into one of the three memory spaces. Register codes
// look at the low three bits, index codes at the low two bits.
// Assumes CODE_W >= 3. Purely combinational.
module rmw_space_decode
    import rmw_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] code,
    input  logic              is_index,
    output space_t            space
);

    localparam logic [2:0] REG_X = 3'd4;
    localparam logic [2:0] REG_Y = 3'd5;
    localparam logic [1:0] IDX_X = 2'd0;
    localparam logic [1:0] IDX_Y = 2'd1;

    // Pick the space from the relevant low bits of the code
    always_comb begin
        space = SPACE_NORMAL;
        if (is_index) begin
            if (code[1:0] == IDX_X)      space = SPACE_X;
            else if (code[1:0] == IDX_Y) space = SPACE_Y;
        end else begin
            if (code[2:0] == REG_X)      space = SPACE_X;
            else if (code[2:0] == REG_Y) space = SPACE_Y;
        end
    end

endmodule

// File: rtl/rmw_alu.sv
// Module: rmw_alu
// Adds or subtracts one and produces the new flag byte for the byte and
// word forms. For byte forms only operand[7:0] matters. Combinational.
module rmw_alu
    import rmw_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 2 * BYTE_W
) (
    input  rmw_op_t           op,
    input  logic [WORD_W-1:0] operand,
    input  logic [BYTE_W-1:0] flags_in,
    output logic [WORD_W-1:0] result,
    output logic [BYTE_W-1:0] flags_next
);

    localparam logic [BYTE_W-1:0] B_ONE  = BYTE_W'(1);
    localparam logic [WORD_W-1:0] W_ONE  = WORD_W'(1);
    localparam logic [BYTE_W-1:0] B_MAX  = '1;
    localparam logic [WORD_W-1:0] W_MAX  = '1;
    localparam logic [BYTE_W-1:0] B_PMAX = {1'b0, {(BYTE_W-1){1'b1}}};
    localparam logic [BYTE_W-1:0] B_NMIN = {1'b1, {(BYTE_W-1){1'b0}}};

    logic [BYTE_W-1:0] lo_in;
    logic [BYTE_W-1:0] res_b;
    logic [WORD_W-1:0] res_w;

    // Step both widths in the selected direction
    always_comb begin
        lo_in = operand[BYTE_W-1:0];
        res_b = op.dec ? (lo_in - B_ONE) : (lo_in + B_ONE);
        res_w = op.dec ? (operand - W_ONE) : (operand + W_ONE);
    end

    // Assemble the result and the flags for the selected width
    always_comb begin
        flags_next = flags_in;
        if (op.word) begin
            result             = res_w;
            flags_next[FLAG_S] = res_w[WORD_W-1];
            flags_next[FLAG_Z] = (res_w == '0);
            flags_next[FLAG_X] = op.dec ? (res_w == W_MAX) : (res_w == '0);
            flags_next[FLAG_N] = 1'b0;
            if (op.dec ? (operand == '0) : (operand == W_MAX))
                flags_next[FLAG_V] = 1'b1;
        end else begin
            result             = {{(WORD_W-BYTE_W){1'b0}}, res_b};
            flags_next[FLAG_S] = res_b[BYTE_W-1];
            flags_next[FLAG_Z] = (res_b == '0);
            flags_next[FLAG_H] = (res_b[3:0] == 4'd0);
            flags_next[FLAG_X] = op.dec ? (lo_in == '0) : (lo_in == B_MAX);
            if (op.dec) flags_next[FLAG_N] = 1'b1;
            if (op.dec ? (lo_in == B_NMIN) : (lo_in == B_PMAX))
                flags_next[FLAG_V] = 1'b1;
        end
    end

endmodule

// File: rtl/rmw_seq.sv
// Module: rmw_seq
// Sequencer for the read-modify-write cycle. It accepts start only in IDLE.
// Byte forms skip the high-byte states. A skipped conditional operation goes
// straight to DONE. Synchronous active-low reset.
module rmw_seq
    import rmw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       skip,
    input  logic       word,
    output rmw_state_t state
);

    rmw_state_t state_nx;

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start) state_nx = skip ? ST_DONE : ST_READ_LO;
            ST_READ_LO:  state_nx = word ? ST_READ_HI : ST_WRITE_LO;
            ST_READ_HI:  state_nx = ST_WRITE_LO;
            ST_WRITE_LO: state_nx = word ? ST_WRITE_HI : ST_DONE;
            ST_WRITE_HI: state_nx = ST_DONE;
            ST_DONE:     state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

endmodule

// File: rtl/rmw_incdec.sv
// Module: rmw_incdec (top)
// Increments or decrements a byte or a little-endian word in one of three
// byte-wide memory spaces through a synchronous memory port. It assumes
// read data arrives one cycle after the address. Operands, space and flags
// are latched when start is taken. flags_out is loaded on the edge that
// enters DONE and is held after that.
module rmw_incdec
    import rmw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dec_mode,
    input  logic              word_mode,
    input  logic              only_if_x,
    input  logic              sel_index,
    input  logic [CODE_W-1:0] sel_code,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [7:0]        flags_in,
    output logic [7:0]        flags_out,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_space,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        mem_wdata,
    output logic              mem_we
);

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);

    rmw_state_t        state;
    rmw_op_t           op_q;
    rmw_op_t           op_in;
    space_t            space_dec;
    space_t            space_q;
    logic [ADDR_W-1:0] base_q;
    logic [BYTE_W-1:0] flags_q;
    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;
    logic [WORD_W-1:0] operand;
    logic [WORD_W-1:0] result;
    logic [BYTE_W-1:0] flags_next;
    logic              accept;
    logic              skip;
    logic              busy;

    // Pack the incoming operation and decide acceptance and skipping
    always_comb begin
        op_in.dec       = dec_mode;
        op_in.word      = word_mode;
        op_in.only_if_x = only_if_x;
        accept          = start && (state == ST_IDLE);
        skip            = !word_mode && only_if_x && !flags_in[FLAG_X];
        busy            = (state != ST_IDLE);
    end

    rmw_space_decode #(.CODE_W(CODE_W)) i_space (
        .code     (sel_code),
        .is_index (sel_index),
        .space    (space_dec)
    );

    rmw_seq i_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .skip  (skip),
        .word  (word_mode),
        .state (state)
    );

    // Latch the operation context when start is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= '0;
            space_q <= SPACE_NORMAL;
            base_q  <= '0;
            flags_q <= '0;
        end else if (accept) begin
            op_q    <= op_in;
            space_q <= space_dec;
            base_q  <= base_addr;
            flags_q <= flags_in;
        end
    end

    // Capture the low byte (word forms) and the high byte as they come back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (state == ST_READ_HI)                lo_q <= mem_rdata;
            if (state == ST_WRITE_LO && op_q.word)  hi_q <= mem_rdata;
        end
    end

    // Word forms use the captured bytes; byte forms use the read data live
    always_comb begin
        operand = op_q.word ? {hi_q, lo_q} : {{(WORD_W-BYTE_W){1'b0}}, mem_rdata};
    end

    rmw_alu #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) i_alu (
        .op         (op_q),
        .operand    (operand),
        .flags_in   (flags_q),
        .result     (result),
        .flags_next (flags_next)
    );

    // Load the result flags on the edge that enters DONE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_out <= '0;
        end else if (accept && skip) begin
            flags_out <= flags_in;
        end else if ((state == ST_WRITE_LO && !op_q.word) || state == ST_WRITE_HI) begin
            flags_out <= flags_next;
        end
    end

    // Drive the memory port from the current state
    always_comb begin
        mem_space = space_q;
        mem_we    = (state == ST_WRITE_LO) || (state == ST_WRITE_HI);
        mem_addr  = base_q;
        mem_wdata = result[BYTE_W-1:0];
        if (state == ST_READ_HI || state == ST_WRITE_HI) begin
            mem_addr  = base_q + A_ONE;
            mem_wdata = result[WORD_W-1:BYTE_W];
        end
        done = (state == ST_DONE);
    end

endmodule

// File: rtl/rmw_incdec_checker.sv
// Module: rmw_incdec_checker
// Temporal checks on the incrementer's ports and sequencer, bound to the top.
module rmw_incdec_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_space,
    input logic [7:0]        flags_out
);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(flags_out));

    assert_hi_after_lo_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    assert_space_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_space));

    assert_no_write_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_we);

    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> busy);

endmodule

bind rmw_incdec rmw_incdec_checker #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_space (mem_space),
    .flags_out (flags_out)
);

// File: tb/test_rmw_incdec.sv
module test_rmw_incdec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dec_mode = 1'b0;
    logic        word_mode = 1'b0;
    logic        only_if_x = 1'b0;
    logic        sel_index = 1'b0;
    logic [7:0]  sel_code = 8'd0;
    logic [15:0] base_addr = 16'd0;
    logic [7:0]  flags_in = 8'd0;
    logic [7:0]  flags_out;
    logic        done;
    logic [15:0] mem_addr;
    logic [1:0]  mem_space;
    logic [7:0]  mem_rdata = 8'd0;
    logic [7:0]  mem_wdata;
    logic        mem_we;

    logic [7:0] mem [0:2][0:15];
    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    rmw_incdec i_rmw_incdec (
        .clk(clk), .rst_n(rst_n), .start(start), .dec_mode(dec_mode),
        .word_mode(word_mode), .only_if_x(only_if_x), .sel_index(sel_index),
        .sel_code(sel_code), .base_addr(base_addr), .flags_in(flags_in),
        .flags_out(flags_out), .done(done), .mem_addr(mem_addr),
        .mem_space(mem_space), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
        .mem_we(mem_we)
    );

    // Synchronous memory model: three spaces of 16 bytes
    always @(posedge clk) begin
        if (mem_space < 2'd3) begin
            mem_rdata <= mem[mem_space][mem_addr[3:0]];
            if (mem_we) mem[mem_space][mem_addr[3:0]] <= mem_wdata;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected complete");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic [7:0] exp_flags(input bit dec, input bit word,
                                       input int opnd, input [7:0] f);
        logic [7:0] r;
        int n;
        r = f;
        if (!word) begin
            n = dec ? opnd - 1 : opnd + 1;
            n = n & 255;
            r[7] = (n >= 128);
            r[6] = (n == 0);
            r[4] = ((n % 16) == 0);
            r[3] = dec ? (opnd == 0) : (opnd == 255);
            if (dec ? (opnd == 128) : (opnd == 127)) r[2] = 1'b1;
            if (dec) r[1] = 1'b1;
        end else begin
            n = dec ? opnd - 1 : opnd + 1;
            n = n & 65535;
            r[7] = (n >= 32768);
            r[6] = (n == 0);
            r[3] = dec ? (n == 65535) : (n == 0);
            r[1] = 1'b0;
            if (dec ? (opnd == 0) : (opnd == 65535)) r[2] = 1'b1;
        end
        return r;
    endfunction

    // Run one operation; poke keeps start high on a decoy address while busy
    task automatic run_op(input bit dec, input bit word, input bit cond,
                          input bit idx, input [7:0] code, input [15:0] a,
                          input [7:0] fin, input bit poke,
                          output int lat, output [7:0] fo);
        int n;
        @(negedge clk);
        dec_mode = dec; word_mode = word; only_if_x = cond;
        sel_index = idx; sel_code = code; base_addr = a; flags_in = fin;
        start = 1'b1;
        @(negedge clk);
        n = 1;
        if (poke) begin
            base_addr = a ^ 16'd8;
            dec_mode = ~dec;
            flags_in = ~fin;
        end else start = 1'b0;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        fo = flags_out;
        lat = n;
        start = 1'b0;
    endtask

    task automatic fill(input [7:0] v);
        for (int s = 0; s < 3; s++)
            for (int i = 0; i < 16; i++) mem[s][i] = v ^ 8'(i) ^ 8'(s * 16);
    endtask

    initial begin
        int lat;
        logic [7:0] fo;
        logic [7:0] fin;
        int wv [0:11];
        wv = '{16'h0000, 16'hFFFF, 16'h00FF, 16'h0100, 16'h7FFF, 16'h8000,
               16'h8001, 16'h7F00, 16'h1234, 16'h0001, 16'hFF00, 16'hFFFE};
        fill(8'h00);
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && flags_out == 8'h00 && mem_we == 1'b0, "reset",
            {done, mem_we, flags_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R8 R10: every byte operand in both directions
        for (int d = 0; d < 2; d++) begin
            for (int v = 0; v < 256; v++) begin
                fin = 8'(v * 37) ^ 8'h5A;
                mem[0][6] = 8'(v);
                mem[0][7] = 8'hC3;
                run_op(d[0], 1'b0, 1'b0, 1'b0, 8'd0, 16'd6, fin, 1'b0, lat, fo);
                chk(lat == 3, "R8 byte latency", lat, 3);
                chk(fo == exp_flags(d[0], 1'b0, v, fin), d ? "R4 flags" : "R3 flags",
                    fo, exp_flags(d[0], 1'b0, v, fin));
                chk(mem[0][6] == 8'(d ? v - 1 : v + 1), "R10 byte value",
                    mem[0][6], 8'(d ? v - 1 : v + 1));
                chk(mem[0][7] == 8'hC3, "R10 neighbour untouched", mem[0][7], 8'hC3);
            end
        end

        // R1 R5 R6 R8: word operands around carry and sign edges
        for (int d = 0; d < 2; d++) begin
            for (int k = 0; k < 12; k++) begin
                int e;
                fin = 8'(k * 53) ^ 8'h96;
                mem[1][4] = wv[k][7:0];
                mem[1][5] = wv[k][15:8];
                run_op(d[0], 1'b1, 1'b0, 1'b0, 8'd4, 16'd4, fin, 1'b0, lat, fo);
                e = (d ? wv[k] - 1 : wv[k] + 1) & 65535;
                chk(lat == 5, "R8 word latency", lat, 5);
                chk(fo == exp_flags(d[0], 1'b1, wv[k], fin), d ? "R6 flags" : "R5 flags",
                    fo, exp_flags(d[0], 1'b1, wv[k], fin));
                chk({mem[1][5], mem[1][4]} == 16'(e), "R1 word value",
                    {mem[1][5], mem[1][4]}, e);
            end
        end

        // R7: conditional byte form, X clear then X set; word ignores it
        for (int x = 0; x < 2; x++) begin
            fin = x ? 8'h2C : 8'h24;
            mem[0][6] = 8'h41;
            run_op(1'b0, 1'b0, 1'b1, 1'b0, 8'd0, 16'd6, fin, 1'b0, lat, fo);
            chk(lat == (x ? 3 : 1), "R7 latency", lat, x ? 3 : 1);
            chk(fo == (x ? exp_flags(1'b0, 1'b0, 8'h41, fin) : fin), "R7 flags",
                fo, x ? exp_flags(1'b0, 1'b0, 8'h41, fin) : fin);
            chk(mem[0][6] == (x ? 8'h42 : 8'h41), "R7 memory", mem[0][6], x ? 8'h42 : 8'h41);
        end
        mem[0][4] = 8'h10; mem[0][5] = 8'h00;
        run_op(1'b1, 1'b1, 1'b1, 1'b0, 8'd0, 16'd4, 8'h00, 1'b0, lat, fo);
        chk(lat == 5 && mem[0][4] == 8'h0F, "R7 word unaffected", {lat[7:0], mem[0][4]}, 16'h050F);

        // R2: every register code and index code
        for (int idx = 0; idx < 2; idx++) begin
            for (int c = 0; c < (idx ? 4 : 8); c++) begin
                int es;
                logic [7:0] code;
                code = 8'(c) | 8'h18 << (idx ? 2 : 3);
                if (idx) es = (c == 0) ? 1 : (c == 1) ? 2 : 0;
                else     es = (c == 4) ? 1 : (c == 5) ? 2 : 0;
                fill(8'h80);
                run_op(1'b0, 1'b0, 1'b0, idx[0], code, 16'd9, 8'h00, 1'b0, lat, fo);
                for (int s = 0; s < 3; s++) begin
                    logic [7:0] exp_b;
                    exp_b = 8'h80 ^ 8'd9 ^ 8'(s * 16);
                    if (s == es) exp_b = exp_b + 8'd1;
                    chk(mem[s][9] == exp_b, "R2 space select", mem[s][9], exp_b);
                end
            end
        end

        // R9: start held high from busy through the done cycle on a decoy
        fill(8'h00);
        mem[2][4] = 8'hFF; mem[2][5] = 8'h12;
        run_op(1'b0, 1'b1, 1'b0, 1'b0, 8'd5, 16'd4, 8'h01, 1'b1, lat, fo);
        chk(lat == 5, "R9 latency under busy start", lat, 5);
        chk({mem[2][5], mem[2][4]} == 16'h1300, "R9 result", {mem[2][5], mem[2][4]}, 16'h1300);
        for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            chk(done == 1'b0, "R9 no extra done", done, 0);
        end
        for (int s = 0; s < 3; s++) begin
            chk(mem[s][12] == (8'd12 ^ 8'(s * 16)), "R9 decoy untouched",
                mem[s][12], 8'd12 ^ 8'(s * 16));
            chk(mem[s][13] == (8'd13 ^ 8'(s * 16)), "R9 decoy untouched",
                mem[s][13], 8'd13 ^ 8'(s * 16));
        end
        chk(flags_out == fo, "R8 flags held", flags_out, fo);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule